// File: doc/BRIEF.md
# Ticket Lock Manager

This block arbitrates a small set of shared locks among several requesters with first-come, first-served fairness. Every lock keeps two counters. One is the ticket dispenser and the other is the service counter. A requester pulses its acquire line with a lock number and receives the current dispenser value as its ticket in one indivisible step. The dispenser then advances. The requester then waits with no further action until the service counter reaches its ticket, and it holds the lock from that point.

A release pulse that names the held lock advances that lock's service counter by one. This passes ownership to the next ticket in line. While a requester waits it only compares its stored ticket against the service counter, so it issues no repeated atomic requests. When several ports acquire the same lock in one cycle, they are numbered by ascending port index within that cycle. A release from a port that does not hold the named lock changes nothing and raises that port's error pulse.

Top module: `ticket_lock_unit`

## Requirements
- R1: After reset every granted output and every error output is low, and all counters of every lock are zero, so the first acquire of any lock is served at once.
- R2: An acquire on a free lock, sampled at clock edge k, makes that port's granted output high after edge k+1 and not before.
- R3: Acquires of one lock that are sampled at different edges are granted in the order in which they were sampled.
- R4: Acquires of one lock that are sampled at the same edge receive consecutive tickets in ascending port-index order, and are granted in that order.
- R5: A valid release sampled at edge r drops the holder's granted output after edge r, and raises the granted output of the next ticket holder after edge r+1.
- R6: Once granted, a port's granted output stays high in every cycle until that port issues a valid release.
- R7: At most one port holds any given lock at a time, and traffic on one lock never delays or grants another lock.
- R8: A release is valid only when the port currently holds the lock and the release names that lock number. Any other release is ignored, leaves all grants unchanged, and pulses that port's error output high for exactly the cycle after the edge that sampled it.
- R9: An acquire from a port that is already waiting or holding is ignored. It takes no ticket and does not disturb the order of the queue.
- R10: The ticket and service counters wrap modulo 2^(clog2(N_REQ)+1), and ordering stays correct through many wraps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| acq_i | input | N_REQ | Per-port acquire pulse |
| rel_i | input | N_REQ | Per-port release pulse |
| lock_id_i | input | N_REQ*LOCK_W | Per-port lock number; port p uses bits [p*LOCK_W +: LOCK_W] |
| granted_o | output | N_REQ | High while the port holds its lock |
| rel_err_o | output | N_REQ | One-cycle pulse after a refused release |

## Verification
The bench builds the block with eight ports and only two locks. This keeps almost every port contending, so queues of up to eight waiters form on a single lock and the 4-bit counters wrap many times during the random phase. With two locks, a release that names the wrong lock is easy to produce. Some cycles also carry acquires on both locks at once, which shows whether the locks stay independent.

// File: rtl/tl_pkg.sv
package tl_pkg;
  typedef enum logic [1:0] {
    PS_IDLE = 2'd0,
    PS_WAIT = 2'd1,
    PS_HOLD = 2'd2
  } port_st_e;
endpackage

// File: rtl/tl_ticket_alloc.sv
module tl_ticket_alloc #(
  parameter int N_REQ  = 8,
  parameter int N_LOCK = 4,
  parameter int LOCK_W = 2,
  parameter int TKT_W  = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N_REQ-1:0]          take_i,
  input  logic [N_REQ*LOCK_W-1:0]   lock_id_i,
  output logic [N_REQ*TKT_W-1:0]    ticket_o,
  output logic [N_LOCK*TKT_W-1:0]   next_o
);
  logic [TKT_W-1:0] next_q [N_LOCK];
  logic [TKT_W-1:0] next_d [N_LOCK];
  logic [TKT_W-1:0] add_cnt [N_LOCK];
  logic [N_LOCK-1:0] upd_en;
  logic [N_REQ-1:0]  lk_take [N_LOCK];
  logic [TKT_W-1:0]  base [N_REQ];
  logic [TKT_W-1:0]  ahead [N_REQ];

  // per-lock view of accepted acquires
  always_comb begin : lock_view
    for (int l = 0; l < N_LOCK; l++) begin
      for (int i = 0; i < N_REQ; i++) begin
        lk_take[l][i] = take_i[i] && (lock_id_i[i*LOCK_W +: LOCK_W] == LOCK_W'(l));
      end
    end
  end

  // ticket = dispenser of the named lock plus lower-index same-lock takers
  always_comb begin : issue
    for (int i = 0; i < N_REQ; i++) begin
      base[i]  = '0;
      ahead[i] = '0;
      for (int l = 0; l < N_LOCK; l++) begin
        if (lock_id_i[i*LOCK_W +: LOCK_W] == LOCK_W'(l)) base[i] = next_q[l];
      end
      for (int j = 0; j < i; j++) begin
        if (take_i[j] &&
            (lock_id_i[j*LOCK_W +: LOCK_W] == lock_id_i[i*LOCK_W +: LOCK_W]))
          ahead[i] = ahead[i] + 1'b1;
      end
      ticket_o[i*TKT_W +: TKT_W] = base[i] + ahead[i];
    end
  end

  always_comb begin : advance
    for (int l = 0; l < N_LOCK; l++) begin
      add_cnt[l] = TKT_W'($countones(lk_take[l]));
      next_d[l]  = next_q[l] + add_cnt[l];
      upd_en[l]  = |lk_take[l];
      next_o[l*TKT_W +: TKT_W] = next_q[l];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin : regs
    if (!rst_n) begin
      for (int l = 0; l < N_LOCK; l++) next_q[l] <= '0;
    end else begin
      for (int l = 0; l < N_LOCK; l++) begin
        if (upd_en[l]) next_q[l] <= next_d[l];
      end
    end
  end

  for (genvar l = 0; l < N_LOCK; l++) begin : g_chk
    // R9
    dispenser_moves_only_on_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (next_q[l] != $past(next_q[l])) |-> $past(|lk_take[l]));
  end
endmodule

// File: rtl/tl_serve_ctr.sv
module tl_serve_ctr #(
  parameter int N_LOCK = 4,
  parameter int TKT_W  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_LOCK-1:0]        adv_i,
  output logic [N_LOCK*TKT_W-1:0]  serve_o
);
  logic [TKT_W-1:0] serve_q [N_LOCK];
  logic [TKT_W-1:0] serve_d [N_LOCK];

  always_comb begin : next_val
    for (int l = 0; l < N_LOCK; l++) begin
      serve_d[l] = serve_q[l] + 1'b1;
      serve_o[l*TKT_W +: TKT_W] = serve_q[l];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin : regs
    if (!rst_n) begin
      for (int l = 0; l < N_LOCK; l++) serve_q[l] <= '0;
    end else begin
      for (int l = 0; l < N_LOCK; l++) begin
        if (adv_i[l]) serve_q[l] <= serve_d[l];
      end
    end
  end

  for (genvar l = 0; l < N_LOCK; l++) begin : g_chk
    // R5
    serve_steps_by_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (serve_q[l] != $past(serve_q[l])) |-> (serve_q[l] == $past(serve_q[l]) + TKT_W'(1)));
  end
endmodule

// File: rtl/tl_port.sv
module tl_port
  import tl_pkg::*;
#(
  parameter int N_LOCK = 4,
  parameter int LOCK_W = 2,
  parameter int TKT_W  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     acq_i,
  input  logic                     rel_i,
  input  logic [LOCK_W-1:0]        id_i,
  input  logic [TKT_W-1:0]         ticket_i,
  input  logic [N_LOCK*TKT_W-1:0]  serve_i,
  output logic                     take_o,
  output logic                     rel_ok_o,
  output logic                     busy_o,
  output logic                     hold_o,
  output logic [LOCK_W-1:0]        lock_o,
  output logic                     err_o
);
  port_st_e          st_q, st_d;
  logic [TKT_W-1:0]  tkt_q;
  logic [LOCK_W-1:0] lock_q;
  logic              err_q, err_d;
  logic [TKT_W-1:0]  serve_sel;
  logic              cap_en;

  always_comb begin : pick_serve
    serve_sel = '0;
    for (int l = 0; l < N_LOCK; l++) begin
      if (lock_q == LOCK_W'(l)) serve_sel = serve_i[l*TKT_W +: TKT_W];
    end
  end

  always_comb begin : next_state
    take_o   = acq_i && (st_q == PS_IDLE);
    rel_ok_o = rel_i && (st_q == PS_HOLD) && (id_i == lock_q);
    cap_en   = take_o;
    err_d    = rel_i && !rel_ok_o;
    st_d     = st_q;
    unique case (st_q)
      PS_IDLE: if (take_o) st_d = PS_WAIT;
      PS_WAIT: if (serve_sel == tkt_q) st_d = PS_HOLD;
      PS_HOLD: if (rel_ok_o) st_d = PS_IDLE;
      default: st_d = PS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin : regs
    if (!rst_n) begin
      st_q   <= PS_IDLE;
      tkt_q  <= '0;
      lock_q <= '0;
      err_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      err_q <= err_d;
      if (cap_en) begin
        tkt_q  <= ticket_i;
        lock_q <= id_i;
      end
    end
  end

  assign busy_o = (st_q != PS_IDLE);
  assign hold_o = (st_q == PS_HOLD);
  assign lock_o = lock_q;
  assign err_o  = err_q;

  // R6
  grant_kept_until_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_o && !rel_ok_o) |=> hold_o);
  // R2
  grant_follows_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_o) |-> $past(st_q == PS_WAIT));
  // R8
  wrong_id_release_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_i && hold_o && (id_i != lock_q)) |=> (hold_o && err_o));
  // R9
  busy_acquire_keeps_ticket_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acq_i && busy_o) |=> (tkt_q == $past(tkt_q)));
endmodule

// File: rtl/ticket_lock_unit.sv
module ticket_lock_unit #(
  parameter int N_REQ  = 8,
  parameter int N_LOCK = 4,
  localparam int LOCK_W = (N_LOCK > 1) ? $clog2(N_LOCK) : 1,
  localparam int TKT_W  = ((N_REQ > 1) ? $clog2(N_REQ) : 1) + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_REQ-1:0]         acq_i,
  input  logic [N_REQ-1:0]         rel_i,
  input  logic [N_REQ*LOCK_W-1:0]  lock_id_i,
  output logic [N_REQ-1:0]         granted_o,
  output logic [N_REQ-1:0]         rel_err_o
);
  logic [N_REQ-1:0]         take;
  logic [N_REQ-1:0]         rel_ok;
  logic [N_REQ-1:0]         busy;
  logic [N_REQ-1:0]         hold;
  logic [N_REQ*LOCK_W-1:0]  lock_of;
  logic [N_REQ*TKT_W-1:0]   ticket;
  logic [N_LOCK*TKT_W-1:0]  next_tkt;
  logic [N_LOCK*TKT_W-1:0]  serve;
  logic [N_LOCK-1:0]        adv;
  logic [N_REQ-1:0]         hold_mask [N_LOCK];
  logic [N_REQ-1:0]         busy_mask [N_LOCK];

  tl_ticket_alloc #(
    .N_REQ(N_REQ), .N_LOCK(N_LOCK), .LOCK_W(LOCK_W), .TKT_W(TKT_W)
  ) u_alloc (
    .clk(clk), .rst_n(rst_n), .take_i(take), .lock_id_i(lock_id_i),
    .ticket_o(ticket), .next_o(next_tkt)
  );

  tl_serve_ctr #(
    .N_LOCK(N_LOCK), .TKT_W(TKT_W)
  ) u_serve (
    .clk(clk), .rst_n(rst_n), .adv_i(adv), .serve_o(serve)
  );

  for (genvar p = 0; p < N_REQ; p++) begin : g_port
    tl_port #(
      .N_LOCK(N_LOCK), .LOCK_W(LOCK_W), .TKT_W(TKT_W)
    ) u_port (
      .clk(clk), .rst_n(rst_n),
      .acq_i(acq_i[p]), .rel_i(rel_i[p]),
      .id_i(lock_id_i[p*LOCK_W +: LOCK_W]),
      .ticket_i(ticket[p*TKT_W +: TKT_W]),
      .serve_i(serve),
      .take_o(take[p]), .rel_ok_o(rel_ok[p]), .busy_o(busy[p]),
      .hold_o(hold[p]), .lock_o(lock_of[p*LOCK_W +: LOCK_W]),
      .err_o(rel_err_o[p])
    );
  end

  // per-lock masks of holders and of ports queued on that lock
  always_comb begin : masks
    for (int l = 0; l < N_LOCK; l++) begin
      adv[l] = 1'b0;
      for (int p = 0; p < N_REQ; p++) begin
        hold_mask[l][p] = hold[p] && (lock_of[p*LOCK_W +: LOCK_W] == LOCK_W'(l));
        busy_mask[l][p] = busy[p] && (lock_of[p*LOCK_W +: LOCK_W] == LOCK_W'(l));
        if (rel_ok[p] && (lock_of[p*LOCK_W +: LOCK_W] == LOCK_W'(l))) adv[l] = 1'b1;
      end
    end
  end

  assign granted_o = hold;

  for (genvar l = 0; l < N_LOCK; l++) begin : g_chk
    // R7
    single_holder_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(hold_mask[l]) <= 1);
    // R10
    outstanding_matches_queue_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (TKT_W'(next_tkt[l*TKT_W +: TKT_W] - serve[l*TKT_W +: TKT_W])
        == TKT_W'($countones(busy_mask[l]))));
  end
endmodule

// File: tb/ticket_lock_unit_bench.sv
module ticket_lock_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 8;
  localparam int NL = 2;
  localparam int LW = 1;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [N-1:0]    acq, rel;
  logic [N*LW-1:0] lid;
  logic [N-1:0]    granted, rel_err;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference queues: per lock, ports in ticket order
  int   q [NL][N];
  int   qlen [NL];
  int   lk [N];
  logic inq [N];
  logic [N-1:0] exp_gnt, exp_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  ticket_lock_unit #(.N_REQ(N), .N_LOCK(NL)) u_ticket_lock_unit (
    .clk(clk), .rst_n(rst_n), .acq_i(acq), .rel_i(rel), .lock_id_i(lid),
    .granted_o(granted), .rel_err_o(rel_err)
  );

  function automatic logic is_head(int p);
    return inq[p] && (qlen[lk[p]] > 0) && (q[lk[p]][0] == p);
  endfunction

  task automatic model_step(input logic [N-1:0] a, input logic [N-1:0] r,
                            input logic [N*LW-1:0] ids);
    logic [N-1:0] head_now, valid, was_in;
    for (int p = 0; p < N; p++) begin
      head_now[p] = is_head(p);
      was_in[p]   = inq[p];
      valid[p]    = r[p] && exp_gnt[p] && (int'(ids[p*LW +: LW]) == lk[p]);
    end
    for (int p = 0; p < N; p++) begin
      if (valid[p]) begin
        for (int k = 0; k < N-1; k++) q[lk[p]][k] = q[lk[p]][k+1];
        qlen[lk[p]]--;
        inq[p] = 1'b0;
      end
    end
    for (int p = 0; p < N; p++) begin
      if (a[p] && !was_in[p]) begin
        lk[p] = int'(ids[p*LW +: LW]);
        q[lk[p]][qlen[lk[p]]] = p;
        qlen[lk[p]]++;
        inq[p] = 1'b1;
      end
    end
    for (int p = 0; p < N; p++) begin
      exp_err[p] = r[p] && !valid[p];
      exp_gnt[p] = head_now[p] && inq[p];
    end
  endtask

  task automatic check_vec(input string tag, input string what,
                           input logic [N-1:0] got, input logic [N-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got=%b exp=%b at %0t", tag, what, got, exp, $time);
    end
  endtask

  task automatic tick(input logic [N-1:0] a, input logic [N-1:0] r,
                      input logic [N*LW-1:0] ids, input string tag);
    acq = a; rel = r; lid = ids;
    model_step(a, r, ids);
    @(negedge clk);
    acq = '0; rel = '0;
    check_vec(tag, "granted", granted, exp_gnt);
    check_vec(tag, "rel_err", rel_err, exp_err);
  endtask

  function automatic logic [N*LW-1:0] all_on(int l);
    logic [N*LW-1:0] v;
    for (int p = 0; p < N; p++) v[p*LW +: LW] = LW'(l);
    return v;
  endfunction

  function automatic logic [N-1:0] bit_of(int p);
    return N'(1) << p;
  endfunction

  task automatic random_tick(input string tag);
    logic [N-1:0] a, r;
    logic [N*LW-1:0] ids;
    a = '0; r = '0; ids = '0;
    for (int p = 0; p < N; p++) begin
      ids[p*LW +: LW] = LW'($urandom_range(0, NL-1));
      if (!inq[p]) begin
        a[p] = ($urandom_range(0, 9) < 3);
        if ($urandom_range(0, 29) == 0) r[p] = 1'b1;
      end else if (exp_gnt[p]) begin
        if ($urandom_range(0, 2) == 0) begin
          r[p] = 1'b1;
          ids[p*LW +: LW] = ($urandom_range(0, 9) == 0) ? LW'(1 - lk[p]) : LW'(lk[p]);
        end
        if ($urandom_range(0, 29) == 0) a[p] = 1'b1;
      end else begin
        if ($urandom_range(0, 29) == 0) a[p] = 1'b1;
        if ($urandom_range(0, 29) == 0) r[p] = 1'b1;
      end
    end
    tick(a, r, ids, tag);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired at %0t", $time);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; acq = '0; rel = '0; lid = '0;
    for (int l = 0; l < NL; l++) qlen[l] = 0;
    for (int p = 0; p < N; p++) begin inq[p] = 1'b0; lk[p] = 0; end
    exp_gnt = '0; exp_err = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check_vec("R1", "granted", granted, '0);
    check_vec("R1", "rel_err", rel_err, '0);

    // R2 free lock: no grant after the sampling edge, grant one edge later
    tick(bit_of(2), '0, all_on(0), "R2");
    tick('0, '0, all_on(0), "R2");
    // R4 same-cycle acquires on lock 1 by ports 5, 1, 3
    tick(bit_of(5) | bit_of(1) | bit_of(3), '0, all_on(1), "R4");
    tick('0, '0, all_on(1), "R4");
    // R9 waiting port 5 re-acquires lock 0: ignored
    tick(bit_of(5), '0, all_on(0), "R9");
    // R8 idle port 6 releases; holder 1 releases naming the wrong lock
    tick('0, bit_of(6), all_on(1), "R8");
    tick('0, bit_of(1), all_on(0), "R8");
    // R6 grants held while idle
    for (int k = 0; k < 10; k++) tick('0, '0, all_on(0), "R6");
    // R5 hand-off 1 -> 3 -> 5
    tick('0, bit_of(1), all_on(1), "R5");
    tick('0, '0, all_on(1), "R5");
    tick('0, bit_of(3), all_on(1), "R4");
    tick('0, '0, all_on(1), "R4");
    tick('0, bit_of(5), all_on(1), "R5");
    tick('0, bit_of(2), all_on(0), "R5");
    tick('0, '0, all_on(0), "R7");
    // R10 many rounds on lock 0 with a second waiter to force wraps
    for (int k = 0; k < 40; k++) begin
      tick(bit_of(0) | bit_of(7), '0, all_on(0), "R10");
      tick('0, '0, all_on(0), "R10");
      tick('0, bit_of(0), all_on(0), "R10");
      tick('0, '0, all_on(0), "R10");
      tick('0, bit_of(7), all_on(0), "R10");
    end
    // R3 / R7 random contention on both locks
    for (int k = 0; k < 4000; k++) random_tick("R3/R7");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule